// File: doc/BRIEF.md
# PLL Control Register Interlock

This block is the software-visible control and status register group of a clock-multiplier PLL. It holds three byte-wide registers on a simple read/write bus. The control register carries an interrupt enable, a lock-change flag, a PLL on/off switch, a base-clock select and a two-bit VCO power-of-two range. The other two registers select the multiplier and the VCO range. The analog loop, the lock detector and the clock switch sit outside the block. The block drives their settings through dedicated outputs.

The registers are not independent. The base-clock select bit can only be raised while the PLL runs with a nonzero VCO range. While the base-clock select is set, the PLL cannot be switched off. While the PLL runs, the two programming registers are frozen. When the bandwidth mode input (`auto_mode`) is low, the interrupt enable, the flag and the reported lock all stay at zero. The lock input is synchronized, and each change of its level sets the flag. A read of the control register clears the flag. A lock edge that arrives in the same cycle as that read keeps the flag set. The interrupt request is the flag gated by the enable.

Top module: `pll_ctl_regs`

## Requirements
- R1: Address 0 is the control register. Its bit 7 is the interrupt enable, bit 6 the lock-change flag, bit 5 the PLL-on bit, bit 4 the base-clock select, bits 3:2 reserved and bits 1:0 the VCO power-of-two range. Address 1 is the multiplier register and address 2 the VCO range register. After reset, address 0 reads 0x20, addresses 1 and 2 read 0x40, and `irq` is 0.
- R2: With `auto_mode` at 1, each level change of `lock_raw`, seen after SYNC_STAGES clock edges of synchronization, sets the flag on the following edge. A bus read of address 0 (`rd_en` high at an edge) clears the flag, unless a lock change is detected in that same cycle.
- R3: `irq` is 1 exactly when the flag and the interrupt enable are both 1 and `auto_mode` is 1.
- R4: While `auto_mode` is 0, bits 7 and 6 of address 0 read 0, `lock_status` is 0, and `irq` is 0. Writes to bit 7 are ignored, and at the next edge the enable and the flag are cleared.
- R5: The base-clock select bit (`base_sel`) is cleared at the next edge, and writes to it are ignored, whenever the PLL-on bit is 0 or the VCO range register is 0x00.
- R6: While the base-clock select bit is 1, a write of 0 to the PLL-on bit is ignored. A write that sets the base-clock select also keeps the PLL-on bit at 1.
- R7: While the PLL-on bit is 1, writes to addresses 1 and 2 are ignored. While it is 0, they load the written byte.
- R8: Bits 3:2 of address 0 always read 0. Any address above 2 reads 0x00, and writes to such an address change nothing.
- R9: A write takes effect on the clock edge at which `wr_en` is sampled. Bits 1:0 of a control write always load `vco_pow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, used to clear the flag |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| lock_raw | input | 1 | Asynchronous lock indication from the detector |
| auto_mode | input | 1 | Automatic bandwidth mode; gates the interrupt logic |
| irq | output | 1 | Interrupt request |
| lock_status | output | 1 | Synchronized lock, gated by auto_mode |
| pll_enable | output | 1 | PLL-on bit |
| base_sel | output | 1 | Base-clock select bit |
| vco_pow | output | 2 | VCO power-of-two range |
| mult_sel | output | 8 | Multiplier register |
| vco_range | output | 8 | VCO range register |

## Verification
The bench builds the block with SYNC_STAGES set to 3 and ADDR_W set to 3, so the lock path is one stage longer than the default. Addresses 3 to 7 are then unmapped and can be probed. The longer lock path lets a toggle of `lock_raw` be timed to land exactly on a clearing read. The wider address bus exercises the zero readback and the ignored writes. Sequences that clear the VCO range while the PLL is off, followed by attempts to raise the base-clock select, reach the forcing rules in both directions. A random phase also toggles `auto_mode` against pending flags.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

  localparam int unsigned REG_W = 8;

  // register map positions used by the decoder and the read mux
  localparam int unsigned SLOT_CTRL  = 0;
  localparam int unsigned SLOT_MULT  = 1;
  localparam int unsigned SLOT_RANGE = 2;
  localparam int unsigned PROG_NUM   = 2;

  // control register bit positions
  localparam int unsigned B_IE   = 7;
  localparam int unsigned B_FLAG = 6;
  localparam int unsigned B_ON   = 5;
  localparam int unsigned B_BCS  = 4;

  typedef struct packed {
    logic       ie;
    logic       flag;
    logic       on;
    logic       bcs;
    logic [1:0] pow;
  } ctrl_state_t;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_raw,
  output logic lock_sync,
  output logic lock_edge
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = lock_raw;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], lock_raw};
    end
  endgenerate

  assign lock_sync = chain_q[STAGES-1];
  assign prev_d    = lock_sync;
  assign lock_edge = lock_sync ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs #(
  parameter int unsigned          W         = 8,
  parameter int unsigned          NUM       = 2,
  parameter logic [W-1:0]         RESET_VAL = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM-1:0]     wr_sel,
  input  logic [W-1:0]       wdata,
  input  logic               frozen,
  output logic [NUM*W-1:0]   regs
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM; gi++) begin : g_reg
      logic [W-1:0] val_q;
      logic [W-1:0] val_d;
      logic         load;

      assign load = wr_sel[gi] & ~frozen;

      always_comb begin
        val_d = val_q;
        if (load) val_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    val_q <= RESET_VAL;
        else if (load) val_q <= val_d;
      end

      assign regs[gi*W +: W] = val_q;
    end
  endgenerate

endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        rd_ctrl,
  input  logic        w_ie,
  input  logic        w_on,
  input  logic        w_bcs,
  input  logic [1:0]  w_pow,
  input  logic        auto_mode,
  input  logic        lock_edge,
  input  logic        range_zero,
  output ctrl_state_t st
);

  ctrl_state_t st_q;
  ctrl_state_t st_d;

  always_comb begin
    st_d = st_q;

    // enable: held low in manual bandwidth mode
    if (!auto_mode)   st_d.ie = 1'b0;
    else if (wr_ctrl) st_d.ie = w_ie;

    // flag: an edge wins over a clearing read
    if (!auto_mode)     st_d.flag = 1'b0;
    else if (lock_edge) st_d.flag = 1'b1;
    else if (rd_ctrl)   st_d.flag = 1'b0;

    // base select needs a running PLL and a nonzero range
    if (!st_q.on || range_zero) st_d.bcs = 1'b0;
    else if (wr_ctrl)           st_d.bcs = w_bcs;

    // PLL stays on while base select is, or is about to be, set
    if (st_q.bcs || st_d.bcs) st_d.on = 1'b1;
    else if (wr_ctrl)         st_d.on = w_on;

    if (wr_ctrl) st_d.pow = w_pow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.ie   <= 1'b0;
      st_q.flag <= 1'b0;
      st_q.on   <= 1'b1;
      st_q.bcs  <= 1'b0;
      st_q.pow  <= 2'b00;
    end else begin
      st_q <= st_d;
    end
  end

  assign st = st_q;

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 2,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] PROG_RESET  = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              lock_raw,
  input  logic              auto_mode,
  output logic              irq,
  output logic              lock_status,
  output logic              pll_enable,
  output logic              base_sel,
  output logic [1:0]        vco_pow,
  output logic [REG_W-1:0]  mult_sel,
  output logic [REG_W-1:0]  vco_range
);

  localparam int unsigned SLOTS = PROG_NUM + 1;

  logic [SLOTS-1:0]          hit;
  logic                      wr_ctrl;
  logic                      rd_ctrl;
  logic [PROG_NUM-1:0]       prog_wr;
  logic [PROG_NUM*REG_W-1:0] prog_flat;
  logic                      lock_sync;
  logic                      lock_edge;
  logic                      range_zero;
  logic                      flag_bit;
  ctrl_state_t               cst;

  genvar gs;
  generate
    for (gs = 0; gs < SLOTS; gs++) begin : g_dec
      assign hit[gs] = (bus_addr == ADDR_W'(gs));
    end
  endgenerate

  assign wr_ctrl = wr_en & hit[SLOT_CTRL];
  assign rd_ctrl = rd_en & hit[SLOT_CTRL];
  assign prog_wr = {PROG_NUM{wr_en}} & hit[SLOTS-1:1];

  pll_lock_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_raw  (lock_raw),
    .lock_sync (lock_sync),
    .lock_edge (lock_edge)
  );

  pll_prog_regs #(
    .W         (REG_W),
    .NUM       (PROG_NUM),
    .RESET_VAL (PROG_RESET)
  ) u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (prog_wr),
    .wdata  (wdata),
    .frozen (cst.on),
    .regs   (prog_flat)
  );

  assign mult_sel   = prog_flat[(SLOT_MULT-1)*REG_W +: REG_W];
  assign vco_range  = prog_flat[(SLOT_RANGE-1)*REG_W +: REG_W];
  assign range_zero = (vco_range == '0);

  pll_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .rd_ctrl    (rd_ctrl),
    .w_ie       (wdata[B_IE]),
    .w_on       (wdata[B_ON]),
    .w_bcs      (wdata[B_BCS]),
    .w_pow      (wdata[1:0]),
    .auto_mode  (auto_mode),
    .lock_edge  (lock_edge),
    .range_zero (range_zero),
    .st         (cst)
  );

  assign flag_bit    = cst.flag;
  assign irq         = cst.ie & cst.flag & auto_mode;
  assign lock_status = lock_sync & auto_mode;
  assign pll_enable  = cst.on;
  assign base_sel    = cst.bcs;
  assign vco_pow     = cst.pow;

  always_comb begin
    rdata = '0;
    if (hit[SLOT_CTRL]) begin
      rdata[B_IE]   = cst.ie & auto_mode;
      rdata[B_FLAG] = cst.flag & auto_mode;
      rdata[B_ON]   = cst.on;
      rdata[B_BCS]  = cst.bcs;
      rdata[1:0]    = cst.pow;
    end else if (hit[SLOT_MULT]) begin
      rdata = mult_sel;
    end else if (hit[SLOT_RANGE]) begin
      rdata = vco_range;
    end
  end

endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       auto_mode,
  input logic       irq,
  input logic       lock_status,
  input logic       lock_sync,
  input logic       flag_bit,
  input logic       pll_enable,
  input logic       base_sel,
  input logic [7:0] mult_sel,
  input logic [7:0] vco_range
);

  AST_BCS_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    base_sel |-> (pll_enable && vco_range != 8'h00)); // R5

  AST_BCS_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    base_sel |=> pll_enable); // R6

  AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pll_enable |=> ($stable(mult_sel) && $stable(vco_range))); // R7

  AST_MANUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> (!irq && !lock_status)); // R4

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !$stable(lock_sync)) |=> flag_bit); // R2

endmodule

bind pll_ctl_regs pll_ctl_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .auto_mode   (auto_mode),
  .irq         (irq),
  .lock_status (lock_status),
  .lock_sync   (lock_sync),
  .flag_bit    (flag_bit),
  .pll_enable  (pll_enable),
  .base_sel    (base_sel),
  .mult_sel    (mult_sel),
  .vco_range   (vco_range)
);

// File: tb/pll_ctl_regs_bench.sv
module pll_ctl_regs_bench;

  localparam int AW   = 3;
  localparam int SYNC = 3;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          wr_en;
  logic          rd_en;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          lock_raw;
  logic          auto_mode;
  logic          irq;
  logic          lock_status;
  logic          pll_enable;
  logic          base_sel;
  logic [1:0]    vco_pow;
  logic [7:0]    mult_sel;
  logic [7:0]    vco_range;

  int tests;
  int fails;
  bit done;

  pll_ctl_regs #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) u_pll_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .lock_raw(lock_raw),
    .auto_mode(auto_mode), .irq(irq), .lock_status(lock_status),
    .pll_enable(pll_enable), .base_sel(base_sel), .vco_pow(vco_pow),
    .mult_sel(mult_sel), .vco_range(vco_range)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference
  bit       m_ie, m_flag, m_on, m_bcs;
  bit [1:0] m_pow;
  bit [7:0] m_mult, m_rng;
  bit       m_sync, m_prev;
  bit       lq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ie = 0; m_flag = 0; m_on = 1; m_bcs = 0; m_pow = 0;
      m_mult = 8'h40; m_rng = 8'h40; m_sync = 0; m_prev = 0;
      lq.delete();
      for (int k = 0; k < SYNC - 1; k++) lq.push_back(1'b0);
    end else begin
      bit saw_edge, wc, rc, allow_bcs, nb, nn;
      saw_edge = (m_sync != m_prev);
      wc = wr_en && (bus_addr == 0);
      rc = rd_en && (bus_addr == 0);
      allow_bcs = m_on && (m_rng != 0);
      nb = allow_bcs ? (wc ? wdata[4] : m_bcs) : 1'b0;
      nn = (m_bcs || nb) ? 1'b1 : (wc ? wdata[5] : m_on);
      if (!m_on && wr_en && bus_addr == 1) m_mult = wdata;
      if (!m_on && wr_en && bus_addr == 2) m_rng  = wdata;
      if (!auto_mode) begin
        m_ie = 0; m_flag = 0;
      end else begin
        if (wc) m_ie = wdata[7];
        if (saw_edge) m_flag = 1;
        else if (rc) m_flag = 0;
      end
      m_bcs = nb; m_on = nn;
      if (wc) m_pow = wdata[1:0];
      m_prev = m_sync;
      lq.push_back(lock_raw);
      m_sync = lq.pop_front();
    end
  end

  function automatic bit [7:0] exp_read(input bit [AW-1:0] a);
    case (a)
      0: exp_read = {m_ie & auto_mode, m_flag & auto_mode, m_on, m_bcs, 2'b00, m_pow};
      1: exp_read = m_mult;
      2: exp_read = m_rng;
      default: exp_read = 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bus_addr == 0 ? "R2 ctrl readback" : "R8 readback",
            rdata, exp_read(bus_addr));
      check("R3 irq", irq, m_ie & m_flag & auto_mode);
      check("R4 lock_status", lock_status, m_sync & auto_mode);
      check("R5 base_sel", base_sel, m_bcs);
      check("R6 pll_enable", pll_enable, m_on);
      check("R7 mult_sel", mult_sel, m_mult);
      check("R7 vco_range", vco_range, m_rng);
      check("R9 vco_pow", vco_pow, m_pow);
    end
  end

  task automatic step(input bit [AW-1:0] a, input bit w, input bit r,
                      input bit [7:0] d, input bit tog);
    @(posedge clk);
    #1;
    bus_addr = a; wr_en = w; rd_en = r; wdata = d;
    if (tog) lock_raw = ~lock_raw;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 0; bus_addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
    lock_raw = 0; auto_mode = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset values
    @(negedge clk);
    check("R1 ctrl reset", rdata, 8'h20);
    check("R1 irq reset", irq, 0);
    step(1, 0, 0, 8'h00, 0); @(negedge clk);
    check("R1 mult reset", rdata, 8'h40);
    step(2, 0, 0, 8'h00, 0); @(negedge clk);
    check("R1 range reset", rdata, 8'h40);

    // R4: manual mode ignores enable writes and lock changes
    step(0, 1, 0, 8'hA0, 0);
    step(0, 0, 0, 8'h00, 1);
    idle(6); @(negedge clk);
    check("R4 enable ignored", rdata[7], 0);
    check("R4 flag hidden", rdata[6], 0);

    // R2/R3: automatic mode, lock toggles both ways
    auto_mode = 1;
    step(0, 1, 0, 8'hA0, 0);
    step(0, 0, 0, 8'h00, 1);
    idle(6); @(negedge clk);
    check("R3 irq after lock fall", irq, 1);
    step(0, 0, 1, 8'h00, 0);
    idle(1); @(negedge clk);
    check("R2 read clears flag", rdata[6], 0);
    step(0, 0, 0, 8'h00, 1);
    idle(6); @(negedge clk);
    check("R2 rise sets flag", rdata[6], 1);
    // R2: reads every cycle while the lock toggles
    for (int i = 0; i < 12; i++) step(0, 0, 1, 8'h00, (i % 3) == 0);
    // R2: toggle timed so the edge lands on a clearing read
    idle(4); step(0, 0, 1, 8'h00, 0); idle(1);
    step(0, 0, 0, 8'h00, 1); idle(SYNC - 1);
    step(0, 0, 1, 8'h00, 0); idle(1); @(negedge clk);
    check("R2 edge beats read", rdata[6], 1);

    // R5/R6: base select and PLL-on interplay
    step(0, 1, 0, 8'h30, 0); idle(1); @(negedge clk);
    check("R5 base select set", base_sel, 1);
    step(0, 1, 0, 8'h00, 0); idle(1); @(negedge clk);
    check("R6 on held", pll_enable, 1);
    step(0, 1, 0, 8'h00, 0); idle(1); @(negedge clk);
    check("R6 on cleared", pll_enable, 0);
    step(0, 1, 0, 8'h10, 0); idle(1); @(negedge clk);
    check("R5 bcs with pll off", base_sel, 0);

    // R7: programming while off, frozen while on
    step(1, 1, 0, 8'h55, 0);
    step(2, 1, 0, 8'h00, 0);
    step(0, 1, 0, 8'h30, 0);
    step(0, 1, 0, 8'h30, 0); idle(1); @(negedge clk);
    check("R5 bcs with zero range", base_sel, 0);
    step(2, 1, 0, 8'h12, 0); idle(1); @(negedge clk);
    check("R7 range frozen", vco_range, 8'h00);
    step(0, 1, 0, 8'h00, 0);
    step(2, 1, 0, 8'h12, 0);
    step(0, 1, 0, 8'h30, 0);
    step(0, 1, 0, 8'h30, 0); idle(1); @(negedge clk);
    check("R5 bcs allowed", base_sel, 1);

    // R8/R9: reserved bits, power field, unmapped slots
    step(0, 1, 0, 8'h3E, 0); idle(1); @(negedge clk);
    check("R8 reserved zero", rdata[3:2], 0);
    check("R9 pow loaded", vco_pow, 2'b10);
    step(5, 1, 0, 8'hFF, 0); step(5, 0, 0, 8'h00, 0); @(negedge clk);
    check("R8 unmapped read", rdata, 8'h00);

    // random phase against the reference
    for (int i = 0; i < 600; i++) begin
      bit [AW-1:0] a;
      a = AW'($urandom_range(0, 3));
      if ((i % 37) == 0) auto_mode = ~auto_mode;
      step(a, $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
           8'($urandom), $urandom_range(0, 4) == 0);
    end
    idle(2);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("[TB] FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule